// File: doc/BRIEF.md
# Low-Voltage Detect Status and Control Register

This block is an 8-bit register, mapped into memory, that sits between an analog supply monitor and the rest of the system. The monitor drives a low-voltage level that can change at any time. The block synchronizes that level and latches it into a sticky trip flag, but only while detection is enabled and the stop-mode rules allow it. It then raises an interrupt request, a system reset request, or both. Software reads the register through a byte-wide bus and writes it there. It clears the flag by writing a one to a dedicated acknowledge bit.

Two small state machines hold the control state. The trip machine has the states CLEAR and TRIPPED. Its transitions are *trip*, taken from CLEAR when a qualified event is seen, and *acknowledge*, taken from TRIPPED on an acknowledge write when no qualified event is present in that cycle. The lock machine has the states OPEN and SEALED. Its only transition is *seal*, taken from OPEN on the first bus write after reset. While the lock is OPEN the detect enable and stop enable bits take the written value. While it is SEALED they keep their value. The interrupt enable and reset enable bits can be written at any time.

Top module: `lowv_status_ctrl`

## Requirements
- R1: The read value is bit 7 trip flag, bit 6 acknowledge (always reads 0), bit 5 interrupt enable, bit 4 reset enable, bit 3 stop enable, bit 2 detect enable, with bits 1 and 0 always reading 0.
- R2: After reset the register reads 0x1C, and the interrupt and reset requests are low.
- R3: The event input passes through a two-flop synchronizer. An event held high from a falling clock edge makes the flag read 1 after the third rising edge.
- R4: The flag sets only while detect enable (bit 2) is 1. With detect enable at 0 an event leaves the flag at 0.
- R5: Writing 1 to bit 6 clears the flag. A write with bit 6 at 0 leaves the flag unchanged.
- R6: If an acknowledge write coincides with a qualified synchronized event, the flag stays 1. A persisting event therefore keeps the flag set.
- R7: The interrupt request is a level equal to the flag ANDed with interrupt enable (bit 5).
- R8: The reset request is a one-cycle pulse, high in the same cycle the flag goes from 0 to 1, and only if reset enable (bit 4) is 1. With reset enable at 0 it stays low.
- R9: While the stop input is high, an event sets the flag only if stop enable (bit 3) is 1.
- R10: The first write after reset loads bits 3 and 2. Later writes leave them unchanged, while bits 5 and 4 remain writable.
- R11: Written values of bits 7, 1 and 0 have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current register value |
| stop_mode | input | 1 | System is in stop mode |
| lv_event_async | input | 1 | Asynchronous low-voltage level from the monitor |
| irq_req | output | 1 | Interrupt request level |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the assertions check that the flag rises only under enabled detection and the stop-mode qualification, that an acknowledge without a coinciding event clears the flag, that the reset request is a single-cycle pulse tied to the flag's rise, and that sealed enable bits never move. The bench's scenarios are the only place where the three-edge synchronizer latency, the reset-time value, the write-once arming on the first write, and set-over-acknowledge priority are shown. The same holds for the ignored reserved bits and stop-mode blocking with stop enable at 0. Some of these need a second reset, so the lock can be armed with different first values.

// File: rtl/lowv_pkg.sv
package lowv_pkg;

    localparam int REG_W      = 8;
    localparam int FLAG_BIT   = 7;
    localparam int ACK_BIT    = 6;
    localparam int IRQEN_BIT  = 5;
    localparam int RSTEN_BIT  = 4;
    localparam int STOPEN_BIT = 3;
    localparam int DETEN_BIT  = 2;

    localparam logic RST_IRQEN  = 1'b0;
    localparam logic RST_RSTEN  = 1'b1;
    localparam logic RST_STOPEN = 1'b1;
    localparam logic RST_DETEN  = 1'b1;

    typedef enum logic {
        FL_CLEAR   = 1'b0,
        FL_TRIPPED = 1'b1
    } flag_state_e;

    typedef enum logic {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/lowv_sync.sv
module lowv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[TOP];

endmodule

// File: rtl/lowv_lock_fsm.sv
module lowv_lock_fsm
    import lowv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_det_en,
    input  logic wr_stop_en,
    output logic det_en,
    output logic stop_en
);

    lock_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    // transition: seal on the first write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (wr_stb) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    // outputs: enable bits load only while open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_en  <= RST_DETEN;
            stop_en <= RST_STOPEN;
        end else if (state_q == LK_OPEN && wr_stb) begin
            det_en  <= wr_det_en;
            stop_en <= wr_stop_en;
        end
    end

    // R10: once sealed, both enables hold
    p_sealed_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED) |=> ($stable(det_en) && $stable(stop_en)));

endmodule

// File: rtl/lowv_flag_fsm.sv
module lowv_flag_fsm
    import lowv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_lvl,
    input  logic det_en,
    input  logic stop_en,
    input  logic stop_mode,
    input  logic rst_en,
    input  logic ack_wr,
    output logic flag,
    output logic rst_pulse
);

    flag_state_e state_q, state_d;
    logic        qualified;
    logic        trip;

    assign qualified = det_en && (!stop_mode || stop_en);
    assign trip      = qualified && event_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    // transitions: trip and acknowledge (trip wins)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR:   if (trip)            state_d = FL_TRIPPED;
            FL_TRIPPED: if (ack_wr && !trip) state_d = FL_CLEAR;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= (state_q == FL_CLEAR) && trip && rst_en;
    end

    assign flag = (state_q == FL_TRIPPED);

    // R4: a rise needs detect enable and the synchronized event
    p_rise_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(det_en && event_lvl));

    // R9: a rise in stop mode needs stop enable
    p_stop_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(!stop_mode || stop_en));

    // R5: acknowledge without an event clears
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack_wr && !event_lvl) |=> !flag);

    // R8: reset request is one cycle and only with a flag rise
    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse);
    p_rst_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $rose(flag));

endmodule

// File: rtl/lowv_status_ctrl.sv
module lowv_status_ctrl
    import lowv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             stop_mode,
    input  logic             lv_event_async,
    output logic             irq_req,
    output logic             sys_rst_req
);

    logic event_sync;
    logic det_en, stop_en;
    logic irq_en_q, rst_en_q;
    logic flag;
    logic ack_wr;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[FLAG_BIT], bus_wdata[1:0]};
    assign ack_wr       = bus_wr && bus_wdata[ACK_BIT];

    lowv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lv_event_async),
        .sync_out (event_sync)
    );

    lowv_lock_fsm u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (bus_wr),
        .wr_det_en  (bus_wdata[DETEN_BIT]),
        .wr_stop_en (bus_wdata[STOPEN_BIT]),
        .det_en     (det_en),
        .stop_en    (stop_en)
    );

    // freely writable enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en_q <= RST_IRQEN;
            rst_en_q <= RST_RSTEN;
        end else if (bus_wr) begin
            irq_en_q <= bus_wdata[IRQEN_BIT];
            rst_en_q <= bus_wdata[RSTEN_BIT];
        end
    end

    lowv_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_lvl (event_sync),
        .det_en    (det_en),
        .stop_en   (stop_en),
        .stop_mode (stop_mode),
        .rst_en    (rst_en_q),
        .ack_wr    (ack_wr),
        .flag      (flag),
        .rst_pulse (sys_rst_req)
    );

    always_comb begin
        bus_rdata             = '0;
        bus_rdata[FLAG_BIT]   = flag;
        bus_rdata[IRQEN_BIT]  = irq_en_q;
        bus_rdata[RSTEN_BIT]  = rst_en_q;
        bus_rdata[STOPEN_BIT] = stop_en;
        bus_rdata[DETEN_BIT]  = det_en;
    end

    assign irq_req = flag && irq_en_q;

    // R7: an interrupt request only with the flag set
    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> bus_rdata[FLAG_BIT]);

endmodule

// File: tb/lowv_status_ctrl_tb.sv
`timescale 1ns/1ps
module lowv_status_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stop_mode = 1'b0;
    logic       lv = 1'b0;
    logic       irq_req, sys_rst_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lowv_status_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .stop_mode(stop_mode), .lv_event_async(lv),
        .irq_req(irq_req), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_s1, m_s2, m_flag, m_ie, m_re, m_se, m_de, m_sealed, m_rst;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_flag = 0; m_ie = 0; m_re = 1;
            m_se = 1; m_de = 1; m_sealed = 0; m_rst = 0;
        end else begin
            int set, ack;
            set = (m_de == 1 && (stop_mode == 0 || m_se == 1) && m_s2 == 1) ? 1 : 0;
            ack = (bus_wr && bus_wdata[6]) ? 1 : 0;
            m_rst = (set == 1 && m_flag == 0 && m_re == 1) ? 1 : 0;
            if (set == 1) m_flag = 1;
            else if (ack == 1) m_flag = 0;
            m_s2 = m_s1;
            m_s1 = lv;
            if (bus_wr) begin
                m_ie = bus_wdata[5];
                m_re = bus_wdata[4];
                if (m_sealed == 0) begin
                    m_se = bus_wdata[3];
                    m_de = bus_wdata[2];
                    m_sealed = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 rdata", bus_rdata, (m_flag << 7) | (m_ie << 5) | (m_re << 4) | (m_se << 3) | (m_de << 2));
            chk("R7 irq", irq_req, m_flag & m_ie);
            chk("R8 rst", sys_rst_req, m_rst);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp<=20000", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; lv = 1'b0; stop_mode = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk("R2 reset rdata", bus_rdata, 8'h1C);
        chk("R2 reset irq", irq_req, 0);
        chk("R2 reset rst", sys_rst_req, 0);
    endtask

    initial begin
        do_reset();

        // R3: latency through the synchronizer, R8 pulse with reset enable
        lv = 1'b1;
        @(negedge clk); chk("R3 edge1", bus_rdata[7], 0);
        @(negedge clk); chk("R3 edge2", bus_rdata[7], 0);
        @(negedge clk); chk("R3 edge3", bus_rdata[7], 1);
        chk("R8 pulse high", sys_rst_req, 1);
        @(negedge clk); chk("R8 pulse one cycle", sys_rst_req, 0);
        lv = 1'b0;
        idle(3);

        // R5 acknowledge on the first write; it also seals (R10)
        wr(8'h6C);
        chk("R5 ack clears", bus_rdata, 8'h2C);
        wr(8'h20);
        chk("R10 sealed bits hold", bus_rdata, 8'h2C);
        wr(8'h83);
        chk("R11 reserved ignored", bus_rdata, 8'h0C);
        wr(8'h30);
        chk("R10 free bits writable", bus_rdata, 8'h3C);
        wr(8'h20);

        // R7 and R8 with reset enable off
        lv = 1'b1;
        idle(3);
        chk("R7 irq level", irq_req, 1);
        chk("R8 no pulse", sys_rst_req, 0);
        wr(8'h20);
        chk("R5 zero ack keeps", bus_rdata, 8'hAC);
        wr(8'h60);
        chk("R6 set beats ack", bus_rdata, 8'hAC);
        wr(8'h00);
        chk("R7 irq masked", irq_req, 0);
        wr(8'h20);
        lv = 1'b0;
        idle(2);
        wr(8'h60);
        chk("R5 ack after drop", bus_rdata, 8'h2C);
        chk("R7 irq drops", irq_req, 0);

        // R9 stop mode with stop enable 0
        do_reset();
        wr(8'h24);
        stop_mode = 1'b1; lv = 1'b1;
        idle(5);
        chk("R9 stop blocks", bus_rdata, 8'h24);
        stop_mode = 1'b0;
        @(negedge clk);
        chk("R9 leaves stop", bus_rdata, 8'hA4);
        lv = 1'b0;

        // R9 stop mode with stop enable 1
        do_reset();
        wr(8'h0C);
        stop_mode = 1'b1; lv = 1'b1;
        idle(3);
        chk("R9 stop enabled", bus_rdata, 8'h8C);
        stop_mode = 1'b0; lv = 1'b0;

        // R4 detect disabled, R10 write-once of 0
        do_reset();
        wr(8'h00);
        lv = 1'b1;
        idle(5);
        chk("R4 no set disabled", bus_rdata, 8'h00);
        wr(8'h04);
        chk("R10 cannot re-enable", bus_rdata, 8'h00);
        lv = 1'b0;
        idle(2);

        finish_run();
    end

endmodule